// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block sequences the system reset of a small microcontroller. It gathers six reset causes into one internal reset: a power-on request, an asynchronous active-low external pin, a watchdog timeout, a low-voltage detect, an illegal-opcode trap and an illegal-address trap. Each cause that fires is recorded in a sticky status register. Software reads that register once and the read clears it. The block also drives the reset-vector address, which depends on a monitor-mode input.

The external pin goes through a two-flop synchronizer. A low-time counter then qualifies it. The pin holds the system in reset for as long as it stays low. However, its status bit is set only after a minimum low time, and that time is much longer while the power-on sequence is still in progress. A free-running system counter runs next to the reset logic. Every internally sourced reset clears it. A pin reset leaves it counting.

Top module: `rstc_top`

## Requirements
- R1: A high level on `wdog_req`, `lvd_req`, `bad_op_req` or `bad_addr_req` at a clock edge makes `sys_rst` high after that edge.
- R2: Once every request has been low for 64 consecutive clock edges, `sys_rst` falls on the 64th of those edges and not earlier.
- R3: While the synchronized external pin is low, `sys_rst` stays high. The synchronizer is two flops deep, so `sys_rst` rises on the third edge after the pin falls.
- R4: Outside the power-on window, the pin status bit (bit 1) is set once the synchronized pin has been low for 67 consecutive edges. A single high sample restarts the count.
- R5: The power-on window runs from a power-on request until `sys_rst` first deasserts. Inside it, the pin status bit needs 4163 consecutive low edges.
- R6: `por` is a synchronous active-high input. While it is high, `stat_q` is 6'b000001 (bit 0 is the power-on cause) and every other bit is cleared.
- R7: Each cause sets only its own bit: watchdog bit 2, low-voltage bit 3, illegal opcode bit 4, illegal address bit 5. Bits already set stay set until a read.
- R8: A high `stat_rd` at a clock edge clears `stat_q` on that edge. A cause that is active on the same edge still sets its bit.
- R9: `sys_count` increments on every edge. After any edge with `por` or an internal cause high, it is 0. An external pin reset never clears it.
- R10: `vec_addr` is 16'hFFFE, or 16'hFEFE when `monitor_mode` was high at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on request, synchronous, active high |
| ext_rst_n | input | 1 | External reset pin, asynchronous, active low |
| wdog_req | input | 1 | Watchdog timeout request |
| lvd_req | input | 1 | Low-voltage detect request |
| bad_op_req | input | 1 | Illegal opcode request |
| bad_addr_req | input | 1 | Illegal address request |
| monitor_mode | input | 1 | Selects the monitor reset vector |
| stat_rd | input | 1 | Status read strobe, clears the status on the edge |
| sys_rst | output | 1 | Internal system reset, active high |
| vec_addr | output | 16 | Reset vector address |
| stat_q | output | 6 | Reset cause status |
| sys_count | output | CNT_W | Free-running system counter |

## Verification
Two things can fall on the same edge: the status register clearing on a read, and a new cause setting its bit. The bench pulses `stat_rd` and `bad_op_req` together. It expects only bit 4 to survive, and a cause on the next edge then adds to that bit instead of replacing it. A second overlap uses the counter. The bench checks that it keeps counting through a long pin reset, and that it restarts from zero on the very edge an internal cause appears.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int SRC_N       = 6;
  localparam int SRC_POR     = 0;
  localparam int SRC_PIN     = 1;
  localparam int SRC_WDOG    = 2;
  localparam int SRC_LVD     = 3;
  localparam int SRC_BADOP   = 4;
  localparam int SRC_BADADDR = 5;
  typedef logic [SRC_N-1:0] src_vec_t;
  localparam logic [15:0] VEC_NORMAL  = 16'hFFFE;
  localparam logic [15:0] VEC_MONITOR = 16'hFEFE;
endpackage

// File: rtl/rstc_pin_qual.sv
module rstc_pin_qual #(
  parameter int PIN_QUAL  = 67,
  parameter int POR_EXTRA = 4096
) (
  input  logic clk,
  input  logic por,
  input  logic pin_n,
  input  logic por_win,
  output logic pin_low,
  output logic pin_qual
);
  localparam int THR_MAX = PIN_QUAL + POR_EXTRA;
  localparam int CW      = $clog2(THR_MAX + 1);
  localparam logic [CW-1:0] THR_NORM = CW'(PIN_QUAL);
  localparam logic [CW-1:0] THR_POR  = CW'(THR_MAX);

  logic          sync1, sync2;
  logic [CW-1:0] low_cnt;
  logic [CW-1:0] thr;

  // two-stage synchronizer for the asynchronous pin
  always_ff @(posedge clk) begin
    sync1 <= pin_n;
    sync2 <= sync1;
  end

  assign pin_low = ~sync2;
  assign thr     = por_win ? THR_POR : THR_NORM;

  // consecutive low-sample counter, restarts on any high sample
  always_ff @(posedge clk) begin
    if (por || !pin_low)
      low_cnt <= '0;
    else if (low_cnt != THR_POR)
      low_cnt <= low_cnt + 1'b1;
  end

  assign pin_qual = pin_low && !por && (low_cnt == thr - 1'b1);
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int STRETCH = 64
) (
  input  logic clk,
  input  logic req,
  output logic sys_rst
);
  localparam int SW = $clog2(STRETCH + 1);
  localparam logic [SW-1:0] LAST = SW'(STRETCH - 1);

  logic [SW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (req) begin
      sys_rst  <= 1'b1;
      hold_cnt <= '0;
    end else if (sys_rst) begin
      if (hold_cnt == LAST)
        sys_rst <= 1'b0;
      else
        hold_cnt <= hold_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rstc_status.sv
module rstc_status
  import rstc_pkg::*;
(
  input  logic     clk,
  input  logic     por,
  input  logic     rd,
  input  src_vec_t set_vec,
  output src_vec_t stat
);
  always_ff @(posedge clk) begin
    if (por) begin
      stat          <= '0;
      stat[SRC_POR] <= 1'b1;
    end else begin
      stat <= (rd ? '0 : stat) | set_vec;
    end
  end
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int STRETCH   = 64,
  parameter int PIN_QUAL  = 67,
  parameter int POR_EXTRA = 4096
) (
  input  logic             clk,
  input  logic             por,
  input  logic             ext_rst_n,
  input  logic             wdog_req,
  input  logic             lvd_req,
  input  logic             bad_op_req,
  input  logic             bad_addr_req,
  input  logic             monitor_mode,
  input  logic             stat_rd,
  output logic             sys_rst,
  output logic [15:0]      vec_addr,
  output logic [SRC_N-1:0] stat_q,
  output logic [CNT_W-1:0] sys_count
);
  logic     pin_low, pin_qual;
  logic     por_win;
  logic     int_req, any_req;
  src_vec_t set_vec;

  assign int_req = por | wdog_req | lvd_req | bad_op_req | bad_addr_req;
  assign any_req = int_req | pin_low;

  always_comb begin
    set_vec              = '0;
    set_vec[SRC_PIN]     = pin_qual;
    set_vec[SRC_WDOG]    = wdog_req;
    set_vec[SRC_LVD]     = lvd_req;
    set_vec[SRC_BADOP]   = bad_op_req;
    set_vec[SRC_BADADDR] = bad_addr_req;
  end

  rstc_pin_qual #(.PIN_QUAL(PIN_QUAL), .POR_EXTRA(POR_EXTRA)) u_pin (
    .clk(clk), .por(por), .pin_n(ext_rst_n), .por_win(por_win),
    .pin_low(pin_low), .pin_qual(pin_qual)
  );

  rstc_stretch #(.STRETCH(STRETCH)) u_stretch (
    .clk(clk), .req(any_req), .sys_rst(sys_rst)
  );

  rstc_status u_status (
    .clk(clk), .por(por), .rd(stat_rd), .set_vec(set_vec), .stat(stat_q)
  );

  // power-on window lasts until the first reset release
  always_ff @(posedge clk) begin
    if (por)
      por_win <= 1'b1;
    else if (!sys_rst)
      por_win <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (int_req)
      sys_count <= '0;
    else
      sys_count <= sys_count + 1'b1;
  end

  always_ff @(posedge clk) begin
    vec_addr <= monitor_mode ? VEC_MONITOR : VEC_NORMAL;
  end
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
  parameter int CNT_W   = 16,
  parameter int STRETCH = 64
) (
  input logic             clk,
  input logic             por,
  input logic             wdog_req,
  input logic             lvd_req,
  input logic             bad_op_req,
  input logic             bad_addr_req,
  input logic             stat_rd,
  input logic             sys_rst,
  input logic [5:0]       stat_q,
  input logic [CNT_W-1:0] sys_count,
  input logic             pin_low,
  input logic             pin_qual
);
  localparam int QW = $clog2(STRETCH + 1) + 1;

  logic          seen = 1'b0;
  logic [QW-1:0] quiet_cnt = '0;
  logic          int_src;

  assign int_src = wdog_req | lvd_req | bad_op_req | bad_addr_req;

  always_ff @(posedge clk) begin
    if (por) seen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (por || int_src || pin_low)
      quiet_cnt <= '0;
    else if (sys_rst)
      quiet_cnt <= quiet_cnt + 1'b1;
  end

  assert_req_sets_rst_R1: assert property (@(posedge clk) disable iff (por || !seen)
    int_src |=> sys_rst);

  assert_release_after_stretch_R2: assert property (@(posedge clk) disable iff (por || !seen)
    $fell(sys_rst) |-> (quiet_cnt == QW'(STRETCH)));

  assert_pin_holds_rst_R3: assert property (@(posedge clk) disable iff (por || !seen)
    pin_low |=> sys_rst);

  assert_por_status_R6: assert property (@(posedge clk) disable iff (!seen)
    por |=> (stat_q == 6'b000001));

  assert_sticky_bits_R7: assert property (@(posedge clk) disable iff (por || !seen)
    !stat_rd |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (por || !seen)
    (stat_rd && !int_src && !pin_qual) |=> (stat_q == 6'b0));

  assert_count_clear_R9: assert property (@(posedge clk) disable iff (por || !seen)
    int_src |=> (sys_count == '0));

  assert_count_step_R9: assert property (@(posedge clk) disable iff (por || !seen)
    !int_src |=> (sys_count == $past(sys_count) + 1'b1));
endmodule

bind rstc_top rstc_checker #(.CNT_W(CNT_W), .STRETCH(STRETCH)) u_rstc_chk (
  .clk(clk), .por(por), .wdog_req(wdog_req), .lvd_req(lvd_req),
  .bad_op_req(bad_op_req), .bad_addr_req(bad_addr_req), .stat_rd(stat_rd),
  .sys_rst(sys_rst), .stat_q(stat_q), .sys_count(sys_count),
  .pin_low(pin_low), .pin_qual(pin_qual)
);

// File: tb/rstc_top_test.sv
`timescale 1ns/1ps
module rstc_top_test;
  localparam int CNT_W = 16;
  localparam int THR_N = 67;
  localparam int THR_P = 4163;

  logic clk = 1'b0;
  logic por = 1'b1, ext_rst_n = 1'b1;
  logic wdog_req = 1'b0, lvd_req = 1'b0, bad_op_req = 1'b0, bad_addr_req = 1'b0;
  logic monitor_mode = 1'b0, stat_rd = 1'b0;
  logic             sys_rst;
  logic [15:0]      vec_addr;
  logic [5:0]       stat_q;
  logic [CNT_W-1:0] sys_count;

  int checks = 0, failures = 0;
  int c0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rstc_top uut (
    .clk(clk), .por(por), .ext_rst_n(ext_rst_n), .wdog_req(wdog_req),
    .lvd_req(lvd_req), .bad_op_req(bad_op_req), .bad_addr_req(bad_addr_req),
    .monitor_mode(monitor_mode), .stat_rd(stat_rd), .sys_rst(sys_rst),
    .vec_addr(vec_addr), .stat_q(stat_q), .sys_count(sys_count)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic read_status();
    stat_rd = 1'b1; tick(1); stat_rd = 1'b0;
  endtask

  initial begin
    // reset state under power-on (R6, R9, R10)
    tick(4);
    chk("R6 reset status", int'(stat_q), 6'b000001);
    chk("R2 reset active", int'(sys_rst), 1);
    chk("R9 count held at zero", int'(sys_count), 0);
    chk("R10 normal vector", int'(vec_addr), 16'hFFFE);
    por = 1'b0;
    tick(63);
    chk("R2 still in reset at 63", int'(sys_rst), 1);
    tick(1);
    chk("R2 released at 64", int'(sys_rst), 0);
    tick(3);

    // pin reset outside power-on window (R3, R4, R9)
    c0 = int'(sys_count);
    ext_rst_n = 1'b0;
    tick(2);
    chk("R3 not yet in reset", int'(sys_rst), 0);
    tick(1);
    chk("R3 pin asserts reset", int'(sys_rst), 1);
    tick(65);
    chk("R4 pin bit not yet set", int'(stat_q[1]), 0);
    tick(1);
    chk("R4 pin bit set after 67", int'(stat_q[1]), 1);
    chk("R9 pin leaves count running", int'(sys_count), (c0 + 69) & 16'hFFFF);
    ext_rst_n = 1'b1;
    tick(65);
    chk("R2 pin release hold", int'(sys_rst), 1);
    tick(1);
    chk("R2 pin release done", int'(sys_rst), 0);

    // short low time and restart (R4)
    read_status();
    chk("R8 read clears", int'(stat_q), 0);
    ext_rst_n = 1'b0; tick(66); ext_rst_n = 1'b1; tick(70);
    chk("R4 66-cycle pulse ignored", int'(stat_q), 0);
    ext_rst_n = 1'b0; tick(40); ext_rst_n = 1'b1; tick(1);
    ext_rst_n = 1'b0; tick(40); ext_rst_n = 1'b1; tick(70);
    chk("R4 count restarts on high", int'(stat_q), 0);

    // watchdog: reset, status, counter clear (R1, R2, R7, R9)
    wdog_req = 1'b1; tick(1); wdog_req = 1'b0;
    chk("R1 watchdog asserts reset", int'(sys_rst), 1);
    chk("R7 watchdog bit", int'(stat_q), 6'b000100);
    chk("R9 internal clears count", int'(sys_count), 0);
    tick(5);
    chk("R9 count resumes", int'(sys_count), 5);
    tick(58);
    chk("R2 watchdog hold 63", int'(sys_rst), 1);
    tick(1);
    chk("R2 watchdog release 64", int'(sys_rst), 0);

    // sticky accumulation (R7)
    lvd_req = 1'b1; tick(1); lvd_req = 1'b0;
    chk("R7 bits accumulate", int'(stat_q), 6'b001100);
    chk("R9 low-voltage clears count", int'(sys_count), 0);

    // read and new cause on the same edge (R8)
    stat_rd = 1'b1; bad_op_req = 1'b1; tick(1);
    stat_rd = 1'b0; bad_op_req = 1'b0;
    chk("R8 new cause survives read", int'(stat_q), 6'b010000);
    bad_addr_req = 1'b1; tick(1); bad_addr_req = 1'b0;
    chk("R7 illegal address bit", int'(stat_q), 6'b110000);
    read_status();
    chk("R8 read clears all", int'(stat_q), 0);

    // vector select (R10)
    monitor_mode = 1'b1; tick(1);
    chk("R10 monitor vector", int'(vec_addr), 16'hFEFE);
    monitor_mode = 1'b0; tick(1);
    chk("R10 vector back", int'(vec_addr), 16'hFFFE);

    // power-on clears other bits (R6)
    wdog_req = 1'b1; tick(1); wdog_req = 1'b0;
    por = 1'b1; tick(2);
    chk("R6 por clears others", int'(stat_q), 6'b000001);

    // pin low across power-on: long qualification (R5)
    ext_rst_n = 1'b0; tick(3); por = 1'b0;
    tick(THR_P - 1);
    chk("R5 pin bit not set at 4162", int'(stat_q[1]), 0);
    tick(1);
    chk("R5 pin bit set at 4163", int'(stat_q), 6'b000011);
    chk("R3 reset held by pin", int'(sys_rst), 1);
    chk("R9 count after power-on", int'(sys_count), THR_P);
    ext_rst_n = 1'b1; tick(70);
    chk("R2 released after pin", int'(sys_rst), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule